// File: doc/BRIEF.md
# DMA Stream Request Selector and Priority Arbiter

This block decides which of several concurrent DMA streams may use a shared transfer bus next. Each stream watches a row of peripheral request lines. A software-written channel field picks the single line in that row that can trigger the stream. A stream is pending when it is enabled and its chosen line is high.

Among the pending streams, the block grants the one with the highest two-bit software priority. When two or more pending streams share that priority, the lowest-numbered stream wins. The grant is registered and stays fixed while the bus moves one data item. The bus pulses an item-done strobe when the item is finished. Arbitration happens again only in a cycle where no grant is held or where that strobe is high.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `grant` is all zeros, `grantIdx` is 0 and `grantValid` is low.
- R2: Stream s is pending only when `streamEn[s]` is 1 and `reqLines[s*8 + c]` is 1, where c is `chanSel[3s+2:3s]`. The other seven request lines of that stream have no effect.
- R3: A stream whose `streamEn` bit is 0 is never granted, whatever its request lines and priority show.
- R4: Field `streamPrio[2s+1:2s]` ranks stream s from highest to lowest as 11, then 10, then 01, then 00. A pending stream with a higher rank always wins over one with a lower rank.
- R5: Among pending streams that share the winning rank, the stream with the lowest index is granted.
- R6: An arbitration slot is any cycle in which `grantValid` is low or `itemDone` is high. At the clock edge that ends a slot, the block registers the winner among the inputs present during that slot. The result is on the outputs in the next cycle.
- R7: While `grantValid` is high and `itemDone` is low, `grant` and `grantIdx` stay unchanged, even if enables, priorities or requests change.
- R8: When a slot has no pending stream, the next cycle shows `grant` all zeros, `grantIdx` 0 and `grantValid` low.
- R9: `grant` has at most one bit set. When `grantValid` is high, the set bit is bit `grantIdx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| streamEn | input | 8 | Per-stream enable |
| chanSel | input | 24 | Channel select: 3 bits per stream, stream s at [3s+2:3s] |
| streamPrio | input | 16 | Priority: 2 bits per stream, stream s at [2s+1:2s] |
| reqLines | input | 64 | Request matrix: 8 lines per stream, stream s channel c at bit 8s+c |
| itemDone | input | 1 | Bus strobe marking that the current item is finished |
| grant | output | 8 | One-hot grant of the winning stream |
| grantIdx | output | 3 | Index of the granted stream |
| grantValid | output | 1 | A grant is held |

## Verification
Two things can happen in the same cycle: the item-done release of the held grant, and the arbitration that picks the next winner. The vector table holds `itemDone` high on every vector, so each vector is released and re-arbitrated in one edge. Directed sequences cover the other cases. A higher-priority request arrives while a grant is held, which must not preempt it. Then a single `itemDone` pulse must hand the grant over in the very next cycle. A second pulse with the same inputs must re-grant the same stream, and a pulse with nothing pending must drop `grantValid` without a gap cycle. Every check compares the grant vector, the index and the valid flag against values worked out from the rank and index rules.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Strobes from control to datapath for the grant register.
  typedef struct packed {
    logic load;   // capture the current winner
    logic clear;  // drop the grant, nothing pending
  } arb_strobe_t;

endpackage

// File: rtl/dma_arb_datapath.sv
module dma_arb_datapath
  import dma_arb_pkg::*;
#(
  parameter int NumStreams  = 8,
  parameter int NumChannels = 8,
  parameter int PrioWidth   = 2,
  localparam int SelWidth   = $clog2(NumChannels),
  localparam int IdxWidth   = $clog2(NumStreams)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NumStreams-1:0]             streamEn,
  input  logic [NumStreams*SelWidth-1:0]    chanSel,
  input  logic [NumStreams*PrioWidth-1:0]   streamPrio,
  input  logic [NumStreams*NumChannels-1:0] reqLines,
  input  arb_strobe_t                       strobes,
  output logic                              anyPending,
  output logic [NumStreams-1:0]             grant,
  output logic [IdxWidth-1:0]               grantIdx
);

  logic [NumStreams-1:0] pending;

  // Per-stream request multiplexer, gated by the enable.
  for (genvar s = 0; s < NumStreams; s++) begin : g_reqMux
    logic [NumChannels-1:0] reqRow;
    logic [SelWidth-1:0]    selField;
    assign reqRow     = reqLines[s*NumChannels +: NumChannels];
    assign selField   = chanSel[s*SelWidth +: SelWidth];
    assign pending[s] = streamEn[s] & reqRow[selField];
  end

  // Priority picker: strict greater-than keeps the lower index on a tie.
  logic                  found;
  logic [IdxWidth-1:0]   bestIdx;
  logic [PrioWidth-1:0]  bestPrio;
  logic [NumStreams-1:0] winOneHot;

  always_comb begin
    found    = 1'b0;
    bestIdx  = '0;
    bestPrio = '0;
    for (int s = 0; s < NumStreams; s++) begin
      if (pending[s] && (!found || (streamPrio[s*PrioWidth +: PrioWidth] > bestPrio))) begin
        found    = 1'b1;
        bestIdx  = IdxWidth'(s);
        bestPrio = streamPrio[s*PrioWidth +: PrioWidth];
      end
    end
    winOneHot = found ? (NumStreams'(1) << bestIdx) : '0;
  end

  assign anyPending = found;

  // Grant register.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      grant    <= '0;
      grantIdx <= '0;
    end else if (strobes.load) begin
      grant    <= winOneHot;
      grantIdx <= bestIdx;
    end else if (strobes.clear) begin
      grant    <= '0;
      grantIdx <= '0;
    end
  end

endmodule

// File: rtl/dma_arb_control.sv
module dma_arb_control
  import dma_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyPending,
  input  logic        itemDone,
  output arb_strobe_t strobes,
  output logic        busy
);

  logic arbSlot;

  // A slot opens when idle or when the current item completes.
  assign arbSlot       = !busy || itemDone;
  assign strobes.load  = arbSlot && anyPending;
  assign strobes.clear = arbSlot && !anyPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              busy <= 1'b0;
    else if (strobes.load)  busy <= 1'b1;
    else if (strobes.clear) busy <= 1'b0;
  end

endmodule

// File: rtl/dma_req_arbiter.sv
module dma_req_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NumStreams  = 8,
  parameter int NumChannels = 8,
  parameter int PrioWidth   = 2,
  localparam int SelWidth   = $clog2(NumChannels),
  localparam int IdxWidth   = $clog2(NumStreams)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NumStreams-1:0]             streamEn,
  input  logic [NumStreams*SelWidth-1:0]    chanSel,
  input  logic [NumStreams*PrioWidth-1:0]   streamPrio,
  input  logic [NumStreams*NumChannels-1:0] reqLines,
  input  logic                              itemDone,
  output logic [NumStreams-1:0]             grant,
  output logic [IdxWidth-1:0]               grantIdx,
  output logic                              grantValid
);

  arb_strobe_t strobes;
  logic        anyPending;

  dma_arb_datapath #(
    .NumStreams (NumStreams),
    .NumChannels(NumChannels),
    .PrioWidth  (PrioWidth)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .streamEn  (streamEn),
    .chanSel   (chanSel),
    .streamPrio(streamPrio),
    .reqLines  (reqLines),
    .strobes   (strobes),
    .anyPending(anyPending),
    .grant     (grant),
    .grantIdx  (grantIdx)
  );

  dma_arb_control u_control (
    .clk       (clk),
    .rstN      (rstN),
    .anyPending(anyPending),
    .itemDone  (itemDone),
    .strobes   (strobes),
    .busy      (grantValid)
  );

endmodule

// File: rtl/dma_req_arbiter_chk.sv
module dma_req_arbiter_chk #(
  parameter int NumStreams = 8,
  localparam int IdxWidth  = $clog2(NumStreams)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NumStreams-1:0] streamEn,
  input logic                  itemDone,
  input logic [NumStreams-1:0] grant,
  input logic [IdxWidth-1:0]   grantIdx,
  input logic                  grantValid
);

  logic [NumStreams-1:0] prevEn;
  always_ff @(posedge clk) prevEn <= streamEn;

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)); // R9

  AST_GRANT_MATCH_IDX: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> grant[grantIdx]); // R9

  AST_VALID_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grant != '0)); // R8

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && !itemDone) |=> ($stable(grant) && $stable(grantIdx))); // R7

  AST_NONE_ENABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    ((!grantValid || itemDone) && (streamEn == '0)) |=> !grantValid); // R8

  AST_GRANT_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (grantValid && (!$past(grantValid) || $past(itemDone))) |-> prevEn[grantIdx]); // R3

endmodule

bind dma_req_arbiter dma_req_arbiter_chk #(.NumStreams(NumStreams)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .streamEn  (streamEn),
  .itemDone  (itemDone),
  .grant     (grant),
  .grantIdx  (grantIdx),
  .grantValid(grantValid)
);

// File: tb/dma_req_arbiter_bench.sv
module dma_req_arbiter_bench;

  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  streamEn;
  logic [23:0] chanSel;
  logic [15:0] streamPrio;
  logic [63:0] reqLines;
  logic        itemDone;
  logic [7:0]  grant;
  logic [2:0]  grantIdx;
  logic        grantValid;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(ClkPeriod/2) clk = ~clk;

  dma_req_arbiter u_dma_req_arbiter (
    .clk       (clk),
    .rstN      (rstN),
    .streamEn  (streamEn),
    .chanSel   (chanSel),
    .streamPrio(streamPrio),
    .reqLines  (reqLines),
    .itemDone  (itemDone),
    .grant     (grant),
    .grantIdx  (grantIdx),
    .grantValid(grantValid)
  );

  typedef struct packed {
    int          tag;
    logic [7:0]  en;
    logic [23:0] sel;
    logic [15:0] prio;
    logic [63:0] req;
    logic        v;
    logic [2:0]  idx;
  } vec_t;

  localparam int NumVecs = 11;
  localparam vec_t Vecs [NumVecs] = '{
    '{8, 8'h00, 24'h000000, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 3'd0}, // R8 none enabled
    '{2, 8'h01, 24'h000003, 16'h0000, 64'h0000_0000_0000_0008, 1'b1, 3'd0}, // R2 selected line
    '{2, 8'h01, 24'h000003, 16'h0000, 64'h0000_0000_0000_0004, 1'b0, 3'd0}, // R2 other line ignored
    '{5, 8'hFF, 24'h000000, 16'h0000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd0}, // R5 all low tie
    '{4, 8'hFF, 24'h000000, 16'h0C00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd5}, // R4 very high wins
    '{5, 8'hFF, 24'h000000, 16'h6020, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd2}, // R5 tie at high
    '{3, 8'h7F, 24'h000000, 16'hC000, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 3'd0}, // R3 disabled top prio
    '{2, 8'hFF, 24'h007000, 16'h0300, 64'h0000_0040_0000_0100, 1'b1, 3'd1}, // R2 wrong channel
    '{4, 8'hFF, 24'h007000, 16'h0300, 64'h0000_0080_0000_0100, 1'b1, 3'd4}, // R4 right channel
    '{4, 8'hFF, 24'h000000, 16'h0040, 64'h0001_0000_0100_0000, 1'b1, 3'd3}, // R4 medium over low
    '{4, 8'hFF, 24'h000000, 16'h2040, 64'h0001_0000_0100_0000, 1'b1, 3'd6}  // R4 high over medium
  };

  task automatic checkOut(input string tag, input logic expV, input logic [2:0] expIdx);
    logic [7:0] expGrant;
    expGrant = expV ? (8'h01 << expIdx) : 8'h00;
    checks++;
    if (grantValid !== expV || grantIdx !== expIdx || grant !== expGrant) begin
      errors++;
      $display("FAIL %s: valid=%b idx=%0d grant=%b expected valid=%b idx=%0d grant=%b",
               tag, grantValid, grantIdx, grant, expV, expIdx, expGrant);
    end
  endtask

  task automatic drive(input logic [7:0] en, input logic [23:0] sel,
                       input logic [15:0] prio, input logic [63:0] req, input logic done_i);
    streamEn   = en;
    chanSel    = sel;
    streamPrio = prio;
    reqLines   = req;
    itemDone   = done_i;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0;
    drive(8'hFF, 24'h0, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    repeat (3) @(negedge clk);
    checkOut("R1 in reset", 1'b0, 3'd0);
    drive(8'h00, 24'h0, 16'h0, 64'h0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    checkOut("R1 after reset", 1'b0, 3'd0);

    // Table walk: itemDone held high so each vector is its own slot.
    for (int i = 0; i < NumVecs; i++) begin
      drive(Vecs[i].en, Vecs[i].sel, Vecs[i].prio, Vecs[i].req, 1'b1);
      @(negedge clk);
      checkOut($sformatf("R%0d vector %0d", Vecs[i].tag, i), Vecs[i].v, Vecs[i].idx);
    end

    // Idle slot without itemDone: R6
    drive(8'h00, 24'h0, 16'h0, 64'h0, 1'b1);
    @(negedge clk);
    drive(8'hFF, 24'h0, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    @(negedge clk);
    checkOut("R6 idle slot grants", 1'b1, 3'd0);

    // Higher priority arrives while held: R7
    drive(8'hFF, 24'h0, 16'h0C00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    repeat (3) @(negedge clk);
    checkOut("R7 no preempt", 1'b1, 3'd0);
    drive(8'hFE, 24'h0, 16'h0C00, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    @(negedge clk);
    checkOut("R7 held after disable", 1'b1, 3'd0);

    // Release and re-arbitrate in the same edge: R6
    itemDone = 1'b1;
    @(negedge clk);
    itemDone = 1'b0;
    checkOut("R6 handover on done", 1'b1, 3'd5);

    // Requests vanish while held: still held until done, then empty: R7, R8
    reqLines = 64'h0;
    repeat (2) @(negedge clk);
    checkOut("R7 held with no requests", 1'b1, 3'd5);
    itemDone = 1'b1;
    @(negedge clk);
    itemDone = 1'b0;
    checkOut("R8 release to none", 1'b0, 3'd0);

    // Same stream re-granted after done: R6
    drive(8'hFF, 24'h0, 16'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
    @(negedge clk);
    checkOut("R6 first grant", 1'b1, 3'd0);
    itemDone = 1'b1;
    @(negedge clk);
    itemDone = 1'b0;
    checkOut("R6 re-grant same stream", 1'b1, 3'd0);

    // Highest index alone: R9 one-hot at top bit
    drive(8'h80, 24'h0, 16'h0, 64'h0100_0000_0000_0000, 1'b1);
    @(negedge clk);
    checkOut("R9 top stream one-hot", 1'b1, 3'd7);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule